// File: doc/BRIEF.md
# Serial Port Host Register Bank

This block is the host-facing register file of a 16550-compatible serial port. The host reaches it through a 3-bit offset, separate read and write strobes, and 8-bit write and read buses. The block keeps the line-control, modem-control, interrupt-enable and scratch registers and the 16-bit baud divisor. It also holds the receive byte and the data-ready and overrun flags. The transmit holding byte, the divisor, the line format fields and the interrupt-enable bits go out to the serial engines as plain signals.

The top bit of the line-control register selects the bank for offsets 0 and 1. When it is clear, those offsets reach the data path and the interrupt-enable register. When it is set, they reach the two divisor bytes. The interrupt from the engines leaves the block only while the OUT2 bit of modem control is set. A stored divisor of zero is presented to the tick generator as one, so the tick generator never stalls.

Read data is combinational from the current state. The side effects of a read (clearing data-ready, clearing overrun) take effect at the clock edge that ends the read strobe.

Top module: `uart_regbank`

## Requirements
- R1: After reset, line control, modem control, interrupt enable and scratch read 0. The stored divisor equals parameter DIV_RESET. The receive flags are clear, and irq is 0 even if irq_pending is 1.
- R2: The bank bit is line-control bit 7 (offset 3). While it is 1, offset 0 reads and writes the divisor low byte and offset 1 reads and writes the divisor high byte.
- R3: While the bank bit is 0, a write to offset 0 stores the byte on tx_data and raises tx_load for exactly the one cycle after the write edge. The divisor is left unchanged.
- R4: While the bank bit is 0, a read of offset 0 returns the held receive byte. It clears data-ready (status bit 0) at that edge, unless a new byte arrives in the same cycle.
- R5: While the bank bit is 0, offset 1 is the interrupt-enable register. Bits 3:0 are stored and drive int_enable, and bits 7:4 read 0.
- R6: A read of offset 2 returns {4'b0000, irq_id, ~irq_pending} whatever the bank bit. A write to offset 2 changes no register.
- R7: Line control reads back the full byte written. Its fields are: word_len = bits 1:0, stop_bits = bit 2, parity_en = bit 3, parity_even = bit 4, parity_stick = bit 5, break_ctl = bit 6.
- R8: Modem control stores bits 4:0, reads bits 7:5 as 0, and drives modem_ctl. OUT2 is bit 3.
- R9: irq equals irq_pending while OUT2 is 1, and is 0 while OUT2 is 0.
- R10: The divisor output equals the stored divisor, or 1 when the stored divisor is 0.
- R11: Line status at offset 5 reads {0, tx_empty, tx_empty, 000, overrun, data_ready}. rx_valid loads the receive byte and sets data-ready. Overrun is set when a byte arrives while data-ready is set and the receive byte is not being read. Reading offset 5 clears overrun. Writes to offset 5 are ignored.
- R12: Offset 6 (modem status) reads 0. Offset 7 is a scratch byte that reads back what was written, in either bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 3 | Register offset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe (side effects at edge) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational |
| tx_data | output | 8 | Transmit holding byte |
| tx_load | output | 1 | One-cycle pulse after a transmit write |
| tx_empty | input | 1 | Transmitter idle, reported in line status |
| rx_data | input | 8 | Byte from receive engine |
| rx_valid | input | 1 | rx_data is valid this cycle |
| irq_pending | input | 1 | Raw interrupt request from the engines |
| irq_id | input | 3 | Interrupt identification code |
| irq | output | 1 | Interrupt to the host, gated by OUT2 |
| int_enable | output | 4 | Interrupt-enable bits |
| divisor | output | 16 | Effective baud divisor (never 0) |
| word_len | output | 2 | Word length select |
| stop_bits | output | 1 | Stop-bit select |
| parity_en | output | 1 | Parity enable |
| parity_even | output | 1 | Even parity select |
| parity_stick | output | 1 | Stick parity select |
| break_ctl | output | 1 | Force break |
| modem_ctl | output | 5 | Modem-control bits, OUT2 at bit 3 |

## Verification
The bench builds the block with DIV_RESET = 0. The divisor output is therefore already at the zero-to-one substitution right out of reset, and R10 is checked before any host write. DATA_W stays at 8, so the divisor is 16 bits wide. Both divisor bytes can be set independently and read back. Every bank-switched offset is tried under both values of the bank bit. The bench also covers these corner cases: a receive byte that arrives in the same cycle as a receive read, and overrun with its clear on a status read.

// File: rtl/uart_rb_pkg.sv
package uart_rb_pkg;

  localparam int OFF_W = 3;

  localparam logic [OFF_W-1:0] OFF_DATA  = 3'd0;
  localparam logic [OFF_W-1:0] OFF_IEN   = 3'd1;
  localparam logic [OFF_W-1:0] OFF_IDENT = 3'd2;
  localparam logic [OFF_W-1:0] OFF_LINE  = 3'd3;
  localparam logic [OFF_W-1:0] OFF_MODEM = 3'd4;
  localparam logic [OFF_W-1:0] OFF_LSTAT = 3'd5;
  localparam logic [OFF_W-1:0] OFF_MSTAT = 3'd6;
  localparam logic [OFF_W-1:0] OFF_SCR   = 3'd7;

  localparam int BANK_BIT = 7;
  localparam int OUT2_BIT = 3;

  typedef struct packed {
    logic wr_thr;
    logic wr_dlo;
    logic wr_dhi;
    logic wr_ien;
    logic wr_line;
    logic wr_modem;
    logic wr_scr;
    logic rd_rbr;
    logic rd_lstat;
  } rb_strobe_t;

  function automatic logic [15:0] eff_divisor(input logic [15:0] stored);
    return (stored == 16'd0) ? 16'd1 : stored;
  endfunction

  function automatic logic [7:0] ident_byte(input logic pend, input logic [2:0] id);
    return {4'b0000, id, ~pend};
  endfunction

  function automatic logic [7:0] lstat_byte(input logic dr, input logic oe, input logic temt);
    return {1'b0, temt, temt, 3'b000, oe, dr};
  endfunction

endpackage

// File: rtl/uart_rb_decode.sv
module uart_rb_decode
  import uart_rb_pkg::*;
(
  input  logic [OFF_W-1:0] addr,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic             bank,
  output rb_strobe_t       strb
);
  always_comb begin
    strb          = '0;
    strb.wr_thr   = wr_en && (addr == OFF_DATA)  && !bank;
    strb.wr_dlo   = wr_en && (addr == OFF_DATA)  &&  bank;
    strb.wr_dhi   = wr_en && (addr == OFF_IEN)   &&  bank;
    strb.wr_ien   = wr_en && (addr == OFF_IEN)   && !bank;
    strb.wr_line  = wr_en && (addr == OFF_LINE);
    strb.wr_modem = wr_en && (addr == OFF_MODEM);
    strb.wr_scr   = wr_en && (addr == OFF_SCR);
    strb.rd_rbr   = rd_en && (addr == OFF_DATA)  && !bank;
    strb.rd_lstat = rd_en && (addr == OFF_LSTAT);
  end
endmodule

// File: rtl/uart_rb_divisor.sv
module uart_rb_divisor
  import uart_rb_pkg::*;
#(
  parameter int                 DATA_W    = 8,
  parameter logic [2*DATA_W-1:0] DIV_RESET = '0,
  localparam int                DIV_W     = 2*DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [DATA_W-1:0] wdata,
  output logic [DIV_W-1:0]  stored,
  output logic [DIV_W-1:0]  effective
);
  logic [DATA_W-1:0] byte_q [2];
  logic              wr_sel [2];

  assign wr_sel[0] = wr_lo;
  assign wr_sel[1] = wr_hi;

  for (genvar i = 0; i < 2; i++) begin : g_byte
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        byte_q[i] <= DIV_RESET[i*DATA_W +: DATA_W];
      else if (wr_sel[i]) byte_q[i] <= wdata;
    end
  end

  assign stored    = {byte_q[1], byte_q[0]};
  assign effective = (stored == '0) ? DIV_W'(1) : stored;
endmodule

// File: rtl/uart_rb_rxhold.sv
module uart_rb_rxhold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              rd_rbr,
  input  logic              rd_lstat,
  output logic [DATA_W-1:0] rbr,
  output logic              data_ready,
  output logic              overrun
);
  logic ovr_event;
  assign ovr_event = rx_valid && data_ready && !rd_rbr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rbr        <= '0;
      data_ready <= 1'b0;
      overrun    <= 1'b0;
    end else begin
      if (rx_valid) rbr <= rx_data;
      if (rx_valid)    data_ready <= 1'b1;
      else if (rd_rbr) data_ready <= 1'b0;
      if (ovr_event)     overrun <= 1'b1;
      else if (rd_lstat) overrun <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_regbank.sv
module uart_regbank
  import uart_rb_pkg::*;
#(
  parameter int                  DATA_W    = 8,
  parameter logic [2*DATA_W-1:0] DIV_RESET = 16'd12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] tx_data,
  output logic              tx_load,
  input  logic              tx_empty,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              rx_valid,
  input  logic              irq_pending,
  input  logic [2:0]        irq_id,
  output logic              irq,
  output logic [3:0]        int_enable,
  output logic [2*DATA_W-1:0] divisor,
  output logic [1:0]        word_len,
  output logic              stop_bits,
  output logic              parity_en,
  output logic              parity_even,
  output logic              parity_stick,
  output logic              break_ctl,
  output logic [4:0]        modem_ctl
);
  localparam int DIV_W = 2*DATA_W;

  logic [DATA_W-1:0] line_q;
  logic [4:0]        modem_q;
  logic [3:0]        ien_q;
  logic [DATA_W-1:0] scr_q;
  logic [DATA_W-1:0] thr_q;
  logic              load_q;

  // Named internal events for the checker
  logic              dlab;
  logic              out2;
  logic              data_ready;
  logic              overrun;
  logic [DIV_W-1:0]  div_reg;
  logic [DATA_W-1:0] rbr;
  rb_strobe_t        strb;

  assign dlab = line_q[BANK_BIT];
  assign out2 = modem_q[OUT2_BIT];

  uart_rb_decode u_dec (
    .addr  (addr),
    .wr_en (wr_en),
    .rd_en (rd_en),
    .bank  (dlab),
    .strb  (strb)
  );

  uart_rb_divisor #(.DATA_W(DATA_W), .DIV_RESET(DIV_RESET)) u_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_lo     (strb.wr_dlo),
    .wr_hi     (strb.wr_dhi),
    .wdata     (wdata),
    .stored    (div_reg),
    .effective (divisor)
  );

  uart_rb_rxhold #(.DATA_W(DATA_W)) u_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_valid   (rx_valid),
    .rx_data    (rx_data),
    .rd_rbr     (strb.rd_rbr),
    .rd_lstat   (strb.rd_lstat),
    .rbr        (rbr),
    .data_ready (data_ready),
    .overrun    (overrun)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q  <= '0;
      modem_q <= '0;
      ien_q   <= '0;
      scr_q   <= '0;
      thr_q   <= '0;
      load_q  <= 1'b0;
    end else begin
      load_q <= strb.wr_thr;
      if (strb.wr_thr)   thr_q   <= wdata;
      if (strb.wr_line)  line_q  <= wdata;
      if (strb.wr_modem) modem_q <= wdata[4:0];
      if (strb.wr_ien)   ien_q   <= wdata[3:0];
      if (strb.wr_scr)   scr_q   <= wdata;
    end
  end

  always_comb begin
    unique case (addr)
      OFF_DATA:  rdata = dlab ? div_reg[DATA_W-1:0] : rbr;
      OFF_IEN:   rdata = dlab ? div_reg[DIV_W-1:DATA_W] : {{(DATA_W-4){1'b0}}, ien_q};
      OFF_IDENT: rdata = DATA_W'(ident_byte(irq_pending, irq_id));
      OFF_LINE:  rdata = line_q;
      OFF_MODEM: rdata = {{(DATA_W-5){1'b0}}, modem_q};
      OFF_LSTAT: rdata = DATA_W'(lstat_byte(data_ready, overrun, tx_empty));
      OFF_MSTAT: rdata = '0;
      default:   rdata = scr_q;
    endcase
  end

  assign tx_data      = thr_q;
  assign tx_load      = load_q;
  assign irq          = irq_pending & out2;
  assign int_enable   = ien_q;
  assign word_len     = line_q[1:0];
  assign stop_bits    = line_q[2];
  assign parity_en    = line_q[3];
  assign parity_even  = line_q[4];
  assign parity_stick = line_q[5];
  assign break_ctl    = line_q[6];
  assign modem_ctl    = modem_q;
endmodule

// File: rtl/uart_regbank_chk.sv
module uart_regbank_chk #(
  parameter int DIV_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       addr,
  input logic             wr_en,
  input logic             rd_en,
  input logic [7:0]       wdata,
  input logic             rx_valid,
  input logic             irq_pending,
  input logic             irq,
  input logic [4:0]       modem_ctl,
  input logic             tx_load,
  input logic [7:0]       tx_data,
  input logic [DIV_W-1:0] divisor,
  input logic             dlab,
  input logic             data_ready,
  input logic [DIV_W-1:0] div_reg
);
  assert_tx_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd0 && !dlab) |=> (tx_load && tx_data == $past(wdata)));

  assert_tx_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == 3'd0 && !dlab) |=> !tx_load);

  assert_div_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && dlab && addr[2:1] == 2'b00) |=> $stable(div_reg));

  assert_dr_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 3'd0 && !dlab && !rx_valid) |=> !data_ready);

  assert_dr_set_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> data_ready);

  assert_irq_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !modem_ctl[3] |-> !irq);

  assert_irq_pass_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (modem_ctl[3] && irq_pending) |-> irq);

  assert_div_nonzero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    divisor != '0);
endmodule

bind uart_regbank uart_regbank_chk #(.DIV_W(2*DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .addr        (addr),
  .wr_en       (wr_en),
  .rd_en       (rd_en),
  .wdata       (wdata),
  .rx_valid    (rx_valid),
  .irq_pending (irq_pending),
  .irq         (irq),
  .modem_ctl   (modem_ctl),
  .tx_load     (tx_load),
  .tx_data     (tx_data),
  .divisor     (divisor),
  .dlab        (dlab),
  .data_ready  (data_ready),
  .div_reg     (div_reg)
);

// File: tb/tb_uart_regbank.sv
module tb_uart_regbank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  addr = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  wdata = '0, rdata, tx_data, rx_data = '0;
  logic        tx_load, tx_empty = 1'b1, rx_valid = 1'b0;
  logic        irq_pending = 1'b0, irq;
  logic [2:0]  irq_id = '0;
  logic [3:0]  int_enable;
  logic [15:0] divisor;
  logic [1:0]  word_len;
  logic        stop_bits, parity_en, parity_even, parity_stick, break_ctl;
  logic [4:0]  modem_ctl;

  int checks = 0;
  int errors = 0;
  logic [7:0] rv;

  always #5 clk = ~clk;

  uart_regbank #(.DATA_W(8), .DIV_RESET(16'h0000)) dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .tx_data(tx_data), .tx_load(tx_load),
    .tx_empty(tx_empty), .rx_data(rx_data), .rx_valid(rx_valid),
    .irq_pending(irq_pending), .irq_id(irq_id), .irq(irq),
    .int_enable(int_enable), .divisor(divisor), .word_len(word_len),
    .stop_bits(stop_bits), .parity_en(parity_en), .parity_even(parity_even),
    .parity_stick(parity_stick), .break_ctl(break_ctl), .modem_ctl(modem_ctl)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1; #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic push(input logic [7:0] d);
    @(negedge clk); rx_data = d; rx_valid = 1'b1;
    @(negedge clk); rx_valid = 1'b0;
  endtask

  task automatic t_reset();
    irq_pending = 1'b1;
    #1;
    chk("R1 irq after reset", 16'(irq), 16'h0);
    irq_pending = 1'b0;
    rd(3'd3, rv); chk("R1 line ctl", 16'(rv), 16'h00);
    rd(3'd4, rv); chk("R1 modem ctl", 16'(rv), 16'h00);
    rd(3'd1, rv); chk("R1 int enable", 16'(rv), 16'h00);
    rd(3'd7, rv); chk("R1 scratch", 16'(rv), 16'h00);
    rd(3'd5, rv); chk("R1 line status", 16'(rv), 16'h60);
    chk("R10 zero divisor maps to 1", divisor, 16'h0001);
  endtask

  task automatic t_divisor();
    wr(3'd3, 8'h80);
    wr(3'd0, 8'h34);
    chk("R2 no tx_load in bank 1", 16'(tx_load), 16'h0);
    wr(3'd1, 8'h12);
    rd(3'd0, rv); chk("R2 div low", 16'(rv), 16'h34);
    rd(3'd1, rv); chk("R2 div high", 16'(rv), 16'h12);
    chk("R10 divisor out", divisor, 16'h1234);
    wr(3'd0, 8'h00); wr(3'd1, 8'h00);
    chk("R10 zero again", divisor, 16'h0001);
    wr(3'd0, 8'h03); wr(3'd1, 8'h02);
    chk("R2 divisor 0203", divisor, 16'h0203);
  endtask

  task automatic t_line();
    wr(3'd3, 8'h1B);
    rd(3'd3, rv); chk("R7 readback", 16'(rv), 16'h1B);
    chk("R7 fields", {9'd0, break_ctl, parity_stick, parity_even, parity_en, stop_bits, word_len},
        16'h001B);
    wr(3'd3, 8'h64);
    chk("R7 fields 2", {9'd0, break_ctl, parity_stick, parity_even, parity_en, stop_bits, word_len},
        16'h0064);
    wr(3'd3, 8'h03);
  endtask

  task automatic t_tx();
    wr(3'd0, 8'hA5);
    chk("R3 tx_load pulse", 16'(tx_load), 16'h1);
    chk("R3 tx_data", 16'(tx_data), 16'h00A5);
    @(negedge clk);
    chk("R3 tx_load one cycle", 16'(tx_load), 16'h0);
    chk("R3 divisor unchanged", divisor, 16'h0203);
  endtask

  task automatic t_ien();
    wr(3'd1, 8'hFF);
    rd(3'd1, rv); chk("R5 ien read", 16'(rv), 16'h0F);
    chk("R5 int_enable", 16'(int_enable), 16'h000F);
    chk("R5 divisor untouched", divisor, 16'h0203);
  endtask

  task automatic t_ident();
    irq_pending = 1'b1; irq_id = 3'b010;
    rd(3'd2, rv); chk("R6 ident pending", 16'(rv), 16'h04);
    wr(3'd3, 8'h83);
    rd(3'd2, rv); chk("R6 ident bank 1", 16'(rv), 16'h04);
    wr(3'd3, 8'h03);
    irq_pending = 1'b0; irq_id = 3'b000;
    rd(3'd2, rv); chk("R6 ident idle", 16'(rv), 16'h01);
    wr(3'd2, 8'hFF);
    rd(3'd3, rv); chk("R6 fifo write no effect line", 16'(rv), 16'h03);
    rd(3'd1, rv); chk("R6 fifo write no effect ien", 16'(rv), 16'h0F);
  endtask

  task automatic t_rx();
    push(8'h5A);
    rd(3'd5, rv); chk("R11 data ready", 16'(rv), 16'h61);
    rd(3'd0, rv); chk("R4 rbr", 16'(rv), 16'h5A);
    rd(3'd5, rv); chk("R4 dr cleared", 16'(rv), 16'h60);
    push(8'h11); push(8'h22);
    rd(3'd5, rv); chk("R11 overrun", 16'(rv), 16'h63);
    rd(3'd5, rv); chk("R11 overrun cleared", 16'(rv), 16'h61);
    rd(3'd0, rv); chk("R11 newest byte", 16'(rv), 16'h22);
    push(8'h33);
    @(negedge clk); addr = 3'd0; rd_en = 1'b1; rx_data = 8'h44; rx_valid = 1'b1;
    #1 rv = rdata;
    @(negedge clk); rd_en = 1'b0; rx_valid = 1'b0;
    chk("R4 same-cycle read old byte", 16'(rv), 16'h33);
    rd(3'd5, rv); chk("R4 dr kept, no overrun", 16'(rv), 16'h61);
    rd(3'd0, rv); chk("R4 new byte", 16'(rv), 16'h44);
    wr(3'd5, 8'hFF);
    rd(3'd5, rv); chk("R11 status write ignored", 16'(rv), 16'h60);
    tx_empty = 1'b0;
    rd(3'd5, rv); chk("R11 tx busy", 16'(rv), 16'h00);
    tx_empty = 1'b1;
  endtask

  task automatic t_modem_irq();
    wr(3'd4, 8'hFF);
    rd(3'd4, rv); chk("R8 modem readback", 16'(rv), 16'h1F);
    chk("R8 modem_ctl", 16'(modem_ctl), 16'h001F);
    irq_pending = 1'b1; #1;
    chk("R9 irq passes with OUT2", 16'(irq), 16'h1);
    wr(3'd4, 8'h17); #1;
    chk("R9 irq masked", 16'(irq), 16'h0);
    irq_pending = 1'b0;
  endtask

  task automatic t_misc();
    rd(3'd6, rv); chk("R12 modem status", 16'(rv), 16'h00);
    wr(3'd7, 8'hC3);
    rd(3'd7, rv); chk("R12 scratch", 16'(rv), 16'hC3);
    wr(3'd3, 8'h80);
    rd(3'd7, rv); chk("R12 scratch bank 1", 16'(rv), 16'hC3);
    chk("R12 divisor intact", divisor, 16'h0203);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_divisor();
    t_line();
    t_tx();
    t_ien();
    t_ident();
    t_rx();
    t_modem_irq();
    t_misc();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule